// File: doc/BRIEF.md
# Event Code Encoder and Serial Framer

This block sits at the edge of a subsystem and turns a bank of discrete event lines into numbered event codes for a central sequencer. Each event line may change at any time relative to the local clock. The block synchronises every line and detects its rising edge, so one edge yields one code. Each code carries a source identifier, the index of the line that fired and a running sequence number. The code is then shipped as a framed word on a single serial output.

Edges that arrive together, or while a frame is still on the line, wait in a small queue. Simultaneous edges enter the queue lowest line first, one per clock. If the queue is full, the event is discarded and a sticky flag records the loss. Sequence numbers count only accepted events, so the receiver sees them without gaps. With the default settings of one bit per clock at 100 MHz, a frame occupies 190 ns. A full queue therefore drains well inside a 5 µs delivery budget.

Top module: `evt_code_encoder`

## Requirements
- R1: During and after reset, `ser_out` is 1, `busy` is 0 and `evt_dropped` is 0.
- R2: Each rising edge on an event line produces exactly one frame. A line held high produces no further frames, and a falling edge produces none.
- R3: The 16-bit code has the source identifier (`SOURCE_ID`) in bits 15:12, the line index in bits 11:8 and the sequence count in bits 7:0. The count is 0 for the first accepted code after reset and rises by one, modulo 256, for each accepted code.
- R4: The line idles at 1. A frame is a 0 start bit, then the 16 code bits with the most significant bit first, then a parity bit equal to the XOR of the code bits (even parity), then a 1 stop bit. Every bit lasts `BIT_CLKS` clocks, and a queued code starts directly after the previous stop bit.
- R5: Edges that land in the same clock are sent in ascending order of line index.
- R6: On an idle block, the start bit appears on `ser_out` no later than 5 clock cycles after an event line rises.
- R7: Up to `FIFO_DEPTH` codes wait behind the frame being sent. An event that finds the queue full is discarded without consuming a sequence number. It sets `evt_dropped`, which stays 1 until reset.
- R8: `busy` is 1 while any event is pending, queued or being transmitted, and 0 once the last stop bit has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one bit period is `BIT_CLKS` cycles of it |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | N_LINES | Event lines, asynchronous to `clk` |
| ser_out | output | 1 | Framed serial code stream, idle high |
| busy | output | 1 | Work pending, queued or on the line |
| evt_dropped | output | 1 | Sticky flag: an event was lost to a full queue |

## Verification
The line bank is driven with every one of the 255 non-empty patterns of simultaneous edges. Each pattern must give exactly as many frames as it has set bits, in ascending line order, with contiguous sequence numbers. Over the whole sweep the sequence count wraps past 255. A long-held level, which must yield a single frame, separates edge detection from level detection. A timed single edge on an idle block measures the start-bit latency. Two full bursts placed close together overrun the queue. The number of frames received and the values of the surviving codes show whether discarded events consumed sequence numbers, and a reset afterwards must clear the sticky flag and restart the count.

// File: rtl/evt_enc_pkg.sv
// Shared code-word layout for the event encoder.
// Assumes a 4/4/8 split of the 16-bit code; the serial framer
// only relies on CODE_W.
package evt_enc_pkg;
    localparam int SRC_W  = 4;
    localparam int LINE_W = 4;
    localparam int SEQ_W  = 8;
    localparam int CODE_W = SRC_W + LINE_W + SEQ_W;

    typedef struct packed {
        logic [SRC_W-1:0]  src;
        logic [LINE_W-1:0] line;
        logic [SEQ_W-1:0]  seq;
    } evt_code_t;
endpackage

// File: rtl/evt_edge_sync.sv
// Two-flop synchroniser plus rising-edge detector, one per event line.
// Assumes lines stay at a level for at least two clocks to be seen.
// rise[i] is a single-cycle pulse two clocks after the line's first
// sampled high.
module evt_edge_sync #(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] async_in,
    output logic [N_LINES-1:0] rise
);
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic [2:0] stage_q;

        // Shift the line through two sync flops and one history flop.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q <= '0;
            else        stage_q <= {stage_q[1:0], async_in[g]};
        end

        assign rise[g] = stage_q[1] & ~stage_q[2];

        assert_one_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
            rise[g] |=> !rise[g]);
    end
endmodule

// File: rtl/evt_code_queue.sv
// Turns edge pulses into code words and queues them for the framer.
// A pending mask collects edges; each clock the lowest set bit is
// encoded and pushed. A push into a full queue is discarded and the
// sticky drop flag is set. Assumes DEPTH is a power of two.
module evt_code_queue
    import evt_enc_pkg::*;
#(
    parameter int               N_LINES   = 8,
    parameter int               DEPTH     = 8,
    parameter logic [SRC_W-1:0] SOURCE_ID = 4'h5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] rise,
    input  logic               pop,
    output evt_code_t          head,
    output logic               valid,
    output logic               pend_any,
    output logic               dropped
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [N_LINES-1:0] pending_q, cand, grant;
    logic [LINE_W-1:0]  gidx;
    logic               any_cand, full, push, drop_now, pop_ok;
    logic [SEQ_W-1:0]   seq_q;
    logic [AW-1:0]      wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]      count_q;
    evt_code_t          mem_q [DEPTH];

    // Pick the lowest-index candidate among old pending and new edges.
    always_comb begin
        cand  = pending_q | rise;
        grant = '0;
        gidx  = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (cand[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                gidx     = LINE_W'(i);
            end
        end
    end

    assign any_cand = |cand;
    assign full     = (count_q == CW'(DEPTH));
    assign push     = any_cand && !full;
    assign drop_now = (any_cand && full) || (|(pending_q & rise));
    assign pop_ok   = pop && valid;

    // Retire the granted line from the pending mask every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pending_q <= '0;
        else        pending_q <= cand & ~grant;
    end

    // Count accepted codes only.
    always_ff @(posedge clk) begin
        if (!rst_n)    seq_q <= '0;
        else if (push) seq_q <= seq_q + 1'b1;
    end

    // Store the new code word at the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem_q[wr_ptr_q] <= '{src: SOURCE_ID, line: gidx, seq: seq_q};
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push)   wr_ptr_q <= wr_ptr_q + 1'b1;
            if (pop_ok) rd_ptr_q <= rd_ptr_q + 1'b1;
            case ({push, pop_ok})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // Hold the loss flag until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        dropped <= 1'b0;
        else if (drop_now) dropped <= 1'b1;
    end

    assign head     = mem_q[rd_ptr_q];
    assign valid    = (count_q != '0);
    assign pend_any = |pending_q;

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));
    assert_drop_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |=> dropped);
    assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (seq_q == $past(seq_q) + 1'b1));
endmodule

// File: rtl/evt_frame_tx.sv
// Serial framer: start bit 0, code MSB first, even parity, stop bit 1.
// Each bit is held BIT_CLKS clocks. A waiting code is loaded at the
// end of the stop bit, so frames may run back to back. Output is
// registered and idles high.
module evt_frame_tx
    import evt_enc_pkg::*;
#(
    parameter int BIT_CLKS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic              valid,
    output logic              pop,
    output logic              tx,
    output logic              active
);
    localparam int FRAME_W = CODE_W + 3;
    localparam int BW      = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
    localparam int NW      = $clog2(FRAME_W);

    logic [FRAME_W-1:0] frame_w;
    logic [FRAME_W-2:0] sreg_q;
    logic [NW-1:0]      left_q;
    logic [BW-1:0]      baud_q;
    logic               tx_q, free;

    assign frame_w = {1'b0, code, ^code, 1'b1};
    assign free    = !active || (baud_q == '0 && left_q == '0);
    assign pop     = valid && free;

    // Load a frame, shift a bit per bit period, or fall idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            tx_q   <= 1'b1;
            sreg_q <= '0;
            left_q <= '0;
            baud_q <= '0;
        end else if (free) begin
            if (valid) begin
                active <= 1'b1;
                tx_q   <= frame_w[FRAME_W-1];
                sreg_q <= frame_w[FRAME_W-2:0];
                left_q <= NW'(FRAME_W - 1);
                baud_q <= BW'(BIT_CLKS - 1);
            end else begin
                active <= 1'b0;
                tx_q   <= 1'b1;
            end
        end else if (baud_q == '0) begin
            tx_q   <= sreg_q[FRAME_W-2];
            sreg_q <= {sreg_q[FRAME_W-3:0], 1'b0};
            left_q <= left_q - 1'b1;
            baud_q <= BW'(BIT_CLKS - 1);
        end else begin
            baud_q <= baud_q - 1'b1;
        end
    end

    assign tx = tx_q;

    assert_bit_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && baud_q != '0) |=> $stable(tx_q));
    assert_idle_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !valid) |=> tx_q);
endmodule

// File: rtl/evt_code_encoder.sv
// Top: event lines in, framed event codes out on one serial line.
// Chain: synchroniser/edge detect -> priority encoder + queue ->
// serial framer. busy covers every stage holding work.
module evt_code_encoder
    import evt_enc_pkg::*;
#(
    parameter int               N_LINES    = 8,
    parameter int               FIFO_DEPTH = 8,
    parameter logic [SRC_W-1:0] SOURCE_ID  = 4'h5,
    parameter int               BIT_CLKS   = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] evt_in,
    output logic               ser_out,
    output logic               busy,
    output logic               evt_dropped
);
    logic [N_LINES-1:0] rise;
    evt_code_t          head;
    logic               q_valid, pop, pend_any, tx_active;

    evt_edge_sync #(.N_LINES(N_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(evt_in), .rise(rise)
    );

    evt_code_queue #(
        .N_LINES(N_LINES), .DEPTH(FIFO_DEPTH), .SOURCE_ID(SOURCE_ID)
    ) u_queue (
        .clk(clk), .rst_n(rst_n), .rise(rise), .pop(pop), .head(head),
        .valid(q_valid), .pend_any(pend_any), .dropped(evt_dropped)
    );

    evt_frame_tx #(.BIT_CLKS(BIT_CLKS)) u_tx (
        .clk(clk), .rst_n(rst_n), .code(head), .valid(q_valid),
        .pop(pop), .tx(ser_out), .active(tx_active)
    );

    assign busy = pend_any | q_valid | tx_active;

    assert_line_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> ser_out);
endmodule

// File: tb/evt_code_encoder_bench.sv
module evt_code_encoder_bench;
    localparam int       N   = 8;
    localparam int       B   = 2;
    localparam logic [3:0] SRC = 4'hA;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0] evt_in = '0;
    logic ser_out, busy, evt_dropped;

    int tests = 0, fails = 0;
    bit done = 0;

    int rx_total = 0;
    bit rx_on = 0;
    int rx_ph;
    logic [15:0] rx_code;
    logic rx_par;
    logic [15:0] rx_log [64];
    logic [7:0] exp_seq = 8'd0;

    always #5 clk = ~clk;

    evt_code_encoder #(.N_LINES(N), .FIFO_DEPTH(8), .SOURCE_ID(SRC), .BIT_CLKS(B)) u_evt_code_encoder (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
        .ser_out(ser_out), .busy(busy), .evt_dropped(evt_dropped));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Receiver: samples each bit mid-period and decodes frames (R4).
    always @(negedge clk) begin
        if (!rst_n) rx_on = 0;
        else if (!rx_on) begin
            if (ser_out == 1'b0) begin rx_on = 1; rx_ph = 0; rx_code = '0; end
        end else begin
            rx_ph++;
            if (rx_ph % B == 0) begin
                if (rx_ph / B <= 16) rx_code = {rx_code[14:0], ser_out};
                else if (rx_ph / B == 17) rx_par = ser_out;
                else begin
                    check(ser_out == 1'b1, "R4 stop bit", ser_out, 1);
                    check(rx_par == ^rx_code, "R4 even parity", rx_par, ^rx_code);
                    rx_log[rx_total % 64] = rx_code;
                    rx_total++;
                    rx_on = 0;
                end
            end
        end
    end

    task automatic wait_idle();
        int n = 0;
        repeat (6) @(negedge clk);
        while ((busy || rx_on) && n < 3000) begin @(negedge clk); n++; end
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_code(input int slot, input int line, input string req);
        logic [15:0] e = {SRC, 4'(line), exp_seq};
        check(rx_log[slot % 64] == e, req, rx_log[slot % 64], e);
        exp_seq++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int base, n;
        repeat (4) @(negedge clk);
        // R1: state held in reset
        check(ser_out == 1 && busy == 0 && evt_dropped == 0, "R1 in reset",
              {ser_out, busy, evt_dropped}, 3'b100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(ser_out == 1 && busy == 0 && evt_dropped == 0, "R1 after reset",
              {ser_out, busy, evt_dropped}, 3'b100);

        // R6: latency from idle
        evt_in[6] = 1'b1; n = 0;
        do begin @(negedge clk); n++; end while (ser_out != 1'b0 && n < 20);
        check(n >= 1 && n <= 5, "R6 start-bit latency", n, 5);
        base = rx_total;
        wait_idle();
        check(rx_total - base == 1, "R2 one frame", rx_total - base, 1);
        expect_code(base, 6, "R3 first code after reset");
        evt_in = '0; repeat (4) @(negedge clk);

        // R2: held level yields one frame only, falling edge none
        base = rx_total;
        evt_in[2] = 1'b1;
        repeat (300) @(negedge clk);
        evt_in[2] = 1'b0;
        wait_idle();
        check(rx_total - base == 1, "R2 held level", rx_total - base, 1);
        expect_code(base, 2, "R2 held level code");

        // Sweep of every non-empty simultaneous pattern (R2 R3 R5 R8)
        for (int m = 1; m < 256; m++) begin
            int k;
            base = rx_total;
            evt_in = N'(m);
            repeat (5) @(negedge clk);
            check(busy == 1'b1, "R8 busy while working", busy, 1);
            wait_idle();
            check(busy == 1'b0, "R8 busy clear", busy, 0);
            check(rx_total - base == $countones(m), "R2 frame count",
                  rx_total - base, $countones(m));
            k = base;
            for (int i = 0; i < N; i++) begin
                if (m[i]) begin
                    expect_code(k, i, "R5 order / R3 layout");
                    k++;
                end
            end
            evt_in = '0;
            repeat (4) @(negedge clk);
        end
        check(evt_dropped == 1'b0, "R7 no loss in sweep", evt_dropped, 0);

        // R7: overrun with two close bursts: 8 + 1 accepted
        base = rx_total;
        evt_in = '1;
        repeat (4) @(negedge clk);
        evt_in = '0;
        repeat (4) @(negedge clk);
        evt_in = '1;
        wait_idle();
        check(evt_dropped == 1'b1, "R7 drop flag", evt_dropped, 1);
        check(rx_total - base == 9, "R7 accepted count", rx_total - base, 9);
        for (int i = 0; i < 8; i++) expect_code(base + i, i, "R7 burst one");
        expect_code(base + 8, 0, "R7 no seq consumed by drops");
        evt_in = '0;
        repeat (4) @(negedge clk);

        // R7: flag stays after further normal traffic
        base = rx_total;
        evt_in[4] = 1'b1;
        wait_idle();
        check(evt_dropped == 1'b1, "R7 sticky", evt_dropped, 1);
        expect_code(base, 4, "R7 traffic after drop");
        evt_in = '0;

        // R1/R3: reset clears flag and restarts count
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(evt_dropped == 0 && busy == 0 && ser_out == 1, "R1 reset clears",
              {ser_out, busy, evt_dropped}, 3'b100);
        exp_seq = 8'd0;
        base = rx_total;
        evt_in[7] = 1'b1;
        wait_idle();
        expect_code(base, 7, "R3 count restarts");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule